// File: doc/BRIEF.md
# Serial parity-prefix detector

This block watches a serial bit stream, one bit per accepted clock cycle, and raises a flag whenever the stream received since reset holds an odd number of zeros and an odd number of ones. It does not count beyond parity. Two parity bits, one for zeros and one for ones, hold all the history the decision needs. A detection clears nothing, so the parities run on through any number of hits until the next reset.

An enable input marks the cycles that carry a new bit. In other cycles the machine keeps its state and its flag. The flag is registered. A strobe goes high in the cycle after each accepted bit, so a consumer knows which output cycles carry a fresh decision. A parameter picks the state encoding, either a packed two-bit code or a one-hot code. The behaviour at the ports is the same for both.

Top module: `parity_prefix_det`

## Requirements
- R1: With `rst` high at a rising clock edge (synchronous), the machine returns to the state where both parities are even, and both `det_out` and `det_vld` read 0 after that edge.
- R2: `det_vld` is 1 in the cycle after an edge at which `bit_en` was 1 and `rst` was 0. It is 0 in the cycle after an edge at which `bit_en` was 0.
- R3: After an accepted bit, `det_out` is 1 exactly when the accepted bits since reset, including that bit, contain an odd number of 0s and an odd number of 1s. Bit value 0 counts as a zero and bit value 1 counts as a one.
- R4: A detection does not restart the count. Feeding 0,1,0,0 after reset gives `det_out` = 0,1,0,1.
- R5: While `bit_en` is 0, `bit_in` is ignored. The parities and `det_out` hold their values.
- R6: Feeding the 26 bits 01101010010001111110000100 (leftmost first, one per cycle, from reset) gives the `det_out` sequence 01000100010100000001010000.
- R7: `det_out` is never 1 after two accepted bits in a row, and it is 1 only after an even number of accepted bits since reset.
- R8: Parameter `STATE_STYLE` selects a packed two-bit state (0) or a one-hot state (1), with identical port behaviour. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | High when `bit_in` carries a new bit this cycle |
| bit_in | input | 1 | Serial data bit |
| det_out | output | 1 | Registered flag: odd zeros and odd ones so far |
| det_vld | output | 1 | High for one cycle after each accepted bit |

## Verification
Two situations are hard to reach: a hit that follows an earlier hit with no reset in between, and a hold period during which `bit_in` toggles while `bit_en` is low. The stimulus builds both on purpose. One short sequence hits twice with the parities running on. Another hits, holds with a changing `bit_in`, then resumes and needs the held state to land a second hit. The fixed 26-bit trace and long random runs with random enable gaps and occasional resets are compared against a two-counter model. Both encodings run side by side on the same inputs.

// File: rtl/ppd_pkg.sv
`timescale 1ns/1ps
package ppd_pkg;
   // bit 1: zero-count parity, bit 0: one-count parity (1 = odd)
   typedef enum logic [1:0] {
      PS_EE = 2'b00,
      PS_EO = 2'b01,
      PS_OE = 2'b10,
      PS_OO = 2'b11
   } ppd_state_e;

   localparam int PPD_NUM_STATES = 4;
   localparam int PPD_STYLE_PACKED = 0;
   localparam int PPD_STYLE_ONEHOT = 1;
endpackage

// File: rtl/ppd_next.sv
`timescale 1ns/1ps
module ppd_next
   import ppd_pkg::*;
(
   input  ppd_state_e cur,
   input  logic       bit_in,
   output ppd_state_e nxt
);
   always_comb begin
      unique case (cur)
         PS_EE:   nxt = bit_in ? PS_EO : PS_OE;
         PS_EO:   nxt = bit_in ? PS_EE : PS_OO;
         PS_OE:   nxt = bit_in ? PS_OO : PS_EE;
         PS_OO:   nxt = bit_in ? PS_OE : PS_EO;
         default: nxt = PS_EE;
      endcase
   end
endmodule

// File: rtl/ppd_state_reg.sv
`timescale 1ns/1ps
module ppd_state_reg
   import ppd_pkg::*;
#(
   parameter int STYLE = PPD_STYLE_PACKED
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       en,
   input  ppd_state_e d,
   output ppd_state_e q
);
   localparam int OH_W = PPD_NUM_STATES;

   generate
      if (STYLE == PPD_STYLE_PACKED) begin : g_packed
         ppd_state_e st_q;
         always_ff @(posedge clk) begin
            if (rst)     st_q <= PS_EE;
            else if (en) st_q <= d;
         end
         assign q = st_q;
      end else if (STYLE == PPD_STYLE_ONEHOT) begin : g_onehot
         logic [OH_W-1:0] oh_q;
         logic [OH_W-1:0] oh_d;
         always_comb begin
            oh_d = '0;
            oh_d[d] = 1'b1;
         end
         always_ff @(posedge clk) begin
            if (rst)     oh_q <= OH_W'(1);
            else if (en) oh_q <= oh_d;
         end
         always_comb begin
            q = PS_EE;
            for (int i = 0; i < OH_W; i++) begin
               if (oh_q[i]) q = ppd_state_e'(2'(i));
            end
         end
      end else begin : g_bad
         $error("ppd_state_reg: STYLE must be 0 or 1");
      end
   endgenerate
endmodule

// File: rtl/ppd_out_dec.sv
`timescale 1ns/1ps
module ppd_out_dec
   import ppd_pkg::*;
(
   input  ppd_state_e st,
   output logic       hit
);
   always_comb hit = (st == PS_OO);
endmodule

// File: rtl/parity_prefix_det.sv
`timescale 1ns/1ps
module parity_prefix_det
   import ppd_pkg::*;
#(
   parameter int STATE_STYLE = PPD_STYLE_PACKED
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic bit_in,
   output logic det_out,
   output logic det_vld
);
   if (STATE_STYLE != PPD_STYLE_PACKED && STATE_STYLE != PPD_STYLE_ONEHOT) begin : g_style_chk
      $error("parity_prefix_det: STATE_STYLE out of range");
   end

   ppd_state_e cur_st;
   ppd_state_e nxt_st;
   logic       nxt_hit;

   ppd_next u_next (
      .cur    (cur_st),
      .bit_in (bit_in),
      .nxt    (nxt_st)
   );

   ppd_state_reg #(.STYLE(STATE_STYLE)) u_reg (
      .clk (clk),
      .rst (rst),
      .en  (bit_en),
      .d   (nxt_st),
      .q   (cur_st)
   );

   ppd_out_dec u_dec (
      .st  (nxt_st),
      .hit (nxt_hit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         det_out <= 1'b0;
         det_vld <= 1'b0;
      end else begin
         det_vld <= bit_en;
         if (bit_en) det_out <= nxt_hit;
      end
   end
endmodule

// File: rtl/ppd_chk.sv
`timescale 1ns/1ps
module ppd_chk (
   input logic clk,
   input logic rst,
   input logic bit_en,
   input logic bit_in,
   input logic det_out,
   input logic det_vld
);
   logic len_odd;
   always_ff @(posedge clk) begin
      if (rst)         len_odd <= 1'b0;
      else if (bit_en) len_odd <= ~len_odd;
   end

   AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (!det_out && !det_vld)); // R1
   AST_VLD_ON_BIT: assert property (@(posedge clk) disable iff (rst) bit_en |=> det_vld); // R2
   AST_VLD_IDLE: assert property (@(posedge clk) disable iff (rst) !bit_en |=> !det_vld); // R2
   AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst) !bit_en |=> $stable(det_out)); // R5
   AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst) (bit_en && det_out) |=> !det_out); // R7
   AST_EVEN_LEN_HIT: assert property (@(posedge clk) disable iff (rst) det_out |-> !len_odd); // R7
   AST_BIT_KNOWN: assert property (@(posedge clk) disable iff (rst) bit_en |-> !$isunknown(bit_in)); // R3
endmodule

bind parity_prefix_det ppd_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .bit_en  (bit_en),
   .bit_in  (bit_in),
   .det_out (det_out),
   .det_vld (det_vld)
);

// File: tb/sim_parity_prefix_det.sv
`timescale 1ns/1ps
module sim_parity_prefix_det;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst = 1'b1, bit_en = 1'b0, bit_in = 1'b0;
   logic d0_out, d0_vld, d1_out, d1_vld;
   int   n_chk = 0, n_fail = 0;
   int   zc = 0, oc = 0, acc = 0;
   logic e_out = 1'b0, e_vld = 1'b0;
   bit   finished = 1'b0;

   localparam logic [25:0] TR_IN  = 26'b01101010010001111110000100;
   localparam logic [25:0] TR_OUT = 26'b01000100010100000001010000;

   parity_prefix_det #(.STATE_STYLE(0)) u0 (
      .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
      .det_out(d0_out), .det_vld(d0_vld));

   parity_prefix_det #(.STATE_STYLE(1)) u1 (
      .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
      .det_out(d1_out), .det_vld(d1_vld));

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic r, input logic en, input logic b, input string otag);
      @(negedge clk);
      rst = r; bit_en = en; bit_in = b;
      @(posedge clk);
      #1;
      if (r) begin
         zc = 0; oc = 0; acc = 0; e_out = 1'b0; e_vld = 1'b0;
      end else if (en) begin
         if (b) oc++; else zc++;
         acc++;
         e_out = ((zc % 2) == 1) && ((oc % 2) == 1);
         e_vld = 1'b1;
      end else begin
         e_vld = 1'b0;
      end
      chk(r ? "R1" : otag, "det_out", d0_out, e_out);
      chk(r ? "R1" : "R2", "det_vld", d0_vld, e_vld);
      chk("R8", "onehot det_out", d1_out, e_out);
      chk("R8", "onehot det_vld", d1_vld, e_vld);
      if (!r && d0_out) chk("R7", "hit after odd length", logic'(acc % 2), 1'b0);
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      // R1: reset state
      step(1, 0, 0, "R1");
      step(1, 1, 1, "R1");
      chk("R1", "reset det_out", d0_out, 1'b0);
      chk("R1", "reset det_vld", d0_vld, 1'b0);

      // R4: second hit without restart (0,1,0,0 -> 0,1,0,1)
      step(0, 1, 0, "R4");
      step(0, 1, 1, "R4");
      chk("R4", "first hit", d0_out, 1'b1);
      step(0, 1, 0, "R4");
      step(0, 1, 0, "R4");
      chk("R4", "second hit", d0_out, 1'b1);

      // R5: hold with toggling input, then resume from held state
      step(1, 0, 0, "R1");
      step(0, 1, 0, "R5");
      step(0, 1, 1, "R5");
      for (int k = 0; k < 6; k++) begin
         step(0, 0, logic'(k % 2), "R5");
         chk("R5", "held det_out", d0_out, 1'b1);
      end
      step(0, 1, 0, "R5");
      step(0, 1, 0, "R5");
      chk("R5", "resume uses held state", d0_out, 1'b1);

      // R6: fixed trace from reset
      step(1, 0, 0, "R1");
      for (int i = 25; i >= 0; i--) begin
         step(0, 1, TR_IN[i], "R3");
         chk("R6", "trace det_out", d0_out, TR_OUT[i]);
         chk("R6", "trace onehot det_out", d1_out, TR_OUT[i]);
      end

      // R3/R2: random streams with gaps and occasional resets
      for (int n = 0; n < 4000; n++) begin
         logic r_r, r_en, r_b;
         r_r  = ($urandom_range(0, 199) == 0);
         r_en = ($urandom_range(0, 3) != 0);
         r_b  = logic'($urandom_range(0, 1));
         step(r_r, r_en, r_b, r_en ? "R3" : "R5");
      end

      finished = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R2 watchdog: actual hung expected done");
         report();
         $finish;
      end
   end
endmodule